// File: doc/BRIEF.md
# Teletext Page Request Matcher

This block holds the page requests of a teletext acquisition path and compares every incoming page header against them. The host fills the request slots through a small write port: a pointer load picks a slot group, a slot within the group and a starting column, and each following data write stores one 5-bit entry and steps the column on. Each request is seven entries long. In order they are the magazine, the page tens, the page units, the hours tens, the hours units, the minutes tens and the minutes units. Bit 4 of every entry is a do-care flag.

Headers arrive already hamming-decoded. They come as seven 4-bit digits in the same order, with one error flag per digit. A strobe marks each header. Only the slots of the group selected for acquisition take part. A digit counts only when its do-care flag is set. A request that cares only about magazine and page therefore catches a normal page whatever its subcode. A request that also cares about the time digits catches one timed edition. For every slot that matches, the block issues a found pulse and arms capture. It also keeps a found status bit that is active low.

The hold flag sits in bit 3 of the magazine entry. When this flag is low, the slot freezes after its first capture. Later matches still report the page as found but leave the captured copy untouched.

Top module: `pgm_page_matcher`

## Requirements
- R1: `ptr_load` sets the target group, slot and column. Each `dat_wr` stores `dat_in` at the current column and then moves the column up by one. A write while the column is 7 or above is dropped, and the column stays where it is until the next pointer load.
- R2: Entries are stored per column: column 0 is magazine, 1 page tens, 2 page units, 3 hours tens, 4 hours units, 5 minutes tens, 6 minutes units. `hdr_digit[4c+3:4c]` carries digit c. A cared digit matches when the compared bits are equal. The compared bits are 2..0 for magazine and minutes tens, 1..0 for hours tens, and 3..0 for the rest. Other header bits are ignored.
- R3: A digit whose do-care flag (`dat_in[4]`) is 0 matches any header value.
- R4: An error flag on a cared digit prevents the slot from matching. An error flag on an uncared digit has no effect.
- R5: A slot with no do-care flag set never matches.
- R6: Only the slots of the group given by `acq_group` are compared. The output vectors show those slots, with bit i being slot i of that group.
- R7: A header sampled with `hdr_valid` at clock edge N produces `found_pulse` after edge N+1. The pulse lasts one cycle and has one bit per matching slot.
- R8: `page_found_n` of a slot resets to 1, drops to 0 on a match, and returns to 1 when any entry of that slot is written.
- R9: `capture_en` of a slot rises with a match and falls with the next compared header that does not match that slot.
- R10: When the stored hold flag (bit 3 of column 0) is 0, the first capture freezes the slot. Later matches still pulse `found_pulse` but keep `capture_en` low.
- R11: Writing column 0 of a slot with the hold flag set to 1 releases a freeze.
- R12: After reset, `found_pulse` and `capture_en` are all 0 and `page_found_n` is all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ptr_load | input | 1 | Load the write pointer |
| ptr_group | input | GW | Group of the slot to write |
| ptr_slot | input | SW | Slot within the group |
| ptr_col | input | 3 | Starting column |
| dat_wr | input | 1 | Write one entry and advance the column |
| dat_in | input | 5 | Entry: do-care flag in bit 4, digit in bits 3..0 |
| acq_group | input | GW | Group compared against headers |
| hdr_valid | input | 1 | Header strobe |
| hdr_digit | input | 28 | Seven decoded header digits |
| hdr_err | input | 7 | Hamming error flag per digit |
| found_pulse | output | SLOTS | One-cycle found pulse per slot |
| capture_en | output | SLOTS | Capture armed per slot |
| page_found_n | output | SLOTS | Active-low found status per slot |

## Verification
The assertions assume that the host never issues `ptr_load` and `dat_wr` in the same cycle. They also assume that `acq_group` stays stable from a header strobe until its found pulse, so that a result is credited to the group that was compared. The stimulus meets both conditions: every write is its own one-cycle task, and the group changes only between headers. The vector table covers the mask, error and freeze cases. Directed tests then cover the column overflow, the release of a freeze and the switching of groups.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
   localparam int COLS     = 7;
   localparam int DIG_W    = 4;
   localparam int ENT_W    = DIG_W + 1;
   localparam int COL_AW   = 3;
   localparam int CARE_BIT = DIG_W;
   localparam int HOLD_BIT = 3;

   typedef logic [ENT_W-1:0]  entry_t;
   typedef logic [COL_AW-1:0] col_t;

   // significant digit bits per column; magazine and minutes tens use 3 bits, hours tens 2
   function automatic logic [DIG_W-1:0] digit_mask(input int col);
      case (col)
         0:       return 4'b0111;
         3:       return 4'b0011;
         5:       return 4'b0111;
         default: return 4'b1111;
      endcase
   endfunction
endpackage

// File: rtl/pgm_req_store.sv
module pgm_req_store
   import pgm_pkg::*;
#(
   parameter int GROUPS = 2,
   parameter int SLOTS  = 4,
   localparam int TOTAL = GROUPS * SLOTS,
   localparam int GW    = (GROUPS > 1) ? $clog2(GROUPS) : 1,
   localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int TW    = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ptr_load,
   input  logic [GW-1:0] ptr_group,
   input  logic [SW-1:0] ptr_slot,
   input  col_t          ptr_col,
   input  logic          dat_wr,
   input  entry_t        dat_in,
   output entry_t        req_o [TOTAL][COLS],
   output logic [TOTAL-1:0] wr_hit_o,
   output logic [TOTAL-1:0] release_o
);
   logic [GW-1:0] grp_q;
   logic [SW-1:0] slot_q;
   col_t          col_q;
   int            tgt_i;
   logic [TW-1:0] tgt;
   logic          wr_ok;
   entry_t        mem_q [TOTAL][COLS];

   always_comb begin
      tgt_i = int'(grp_q) * SLOTS + int'(slot_q);
      tgt   = TW'(tgt_i);
      wr_ok = dat_wr && !ptr_load && (col_q < col_t'(COLS)) && (tgt_i < TOTAL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_q  <= '0;
         slot_q <= '0;
         col_q  <= '0;
      end else if (ptr_load) begin
         grp_q  <= ptr_group;
         slot_q <= ptr_slot;
         col_q  <= ptr_col;
      end else if (wr_ok) begin
         col_q  <= col_q + col_t'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < TOTAL; s++)
            for (int c = 0; c < COLS; c++)
               mem_q[s][c] <= '0;
      end else if (wr_ok) begin
         mem_q[tgt][col_q] <= dat_in;
      end
   end

   for (genvar s = 0; s < TOTAL; s++) begin : g_flags
      assign wr_hit_o[s]  = wr_ok && (tgt_i == s);
      assign release_o[s] = wr_ok && (tgt_i == s) && (col_q == '0) && dat_in[HOLD_BIT];
   end

   assign req_o = mem_q;
endmodule

// File: rtl/pgm_slot_cmp.sv
module pgm_slot_cmp
   import pgm_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   hdr_valid,
   input  logic [COLS*DIG_W-1:0]  hdr_digit,
   input  logic [COLS-1:0]        hdr_err,
   input  entry_t                 req_i [COLS],
   output logic                   match_q
);
   logic [COLS-1:0] care;
   logic [COLS-1:0] dig_ok;
   logic            hit;

   for (genvar c = 0; c < COLS; c++) begin : g_dig
      logic [DIG_W-1:0] diff;
      assign care[c]   = req_i[c][CARE_BIT];
      assign diff      = (hdr_digit[c*DIG_W +: DIG_W] ^ req_i[c][DIG_W-1:0]) & digit_mask(c);
      assign dig_ok[c] = !care[c] || ((diff == '0) && !hdr_err[c]);
   end

   assign hit = hdr_valid && (|care) && (&dig_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q <= 1'b0;
      else        match_q <= hit;
   end

   // R4
   err_blocks_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && |(hdr_err & care) |=> !match_q);

   // R5
   empty_slot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (care == '0) |=> !match_q);
endmodule

// File: rtl/pgm_slot_ctl.sv
module pgm_slot_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic res_valid,
   input  logic hit,
   input  logic hold_flag,
   input  logic wr_hit,
   input  logic hold_release,
   output logic found_pulse,
   output logic capture_en,
   output logic found_n
);
   logic frozen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         found_pulse <= 1'b0;
         capture_en  <= 1'b0;
         found_n     <= 1'b1;
         frozen_q    <= 1'b0;
      end else begin
         found_pulse <= res_valid && hit;
         if (res_valid) begin
            if (hit) begin
               capture_en <= !frozen_q;
               if (!frozen_q && !hold_flag) frozen_q <= 1'b1;
            end else begin
               capture_en <= 1'b0;
            end
         end
         if (hold_release) frozen_q <= 1'b0;
         if (res_valid && hit) found_n <= 1'b0;
         else if (wr_hit)      found_n <= 1'b1;
      end
   end

   // R9
   cap_needs_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(capture_en) |-> found_pulse);

   // R10
   frozen_no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frozen_q && $past(frozen_q) |-> !$rose(capture_en));

   // R8
   found_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      found_pulse |-> !found_n);
endmodule

// File: rtl/pgm_page_matcher.sv
module pgm_page_matcher
   import pgm_pkg::*;
#(
   parameter int GROUPS = 2,
   parameter int SLOTS  = 4,
   localparam int TOTAL = GROUPS * SLOTS,
   localparam int GW    = (GROUPS > 1) ? $clog2(GROUPS) : 1,
   localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ptr_load,
   input  logic [GW-1:0]         ptr_group,
   input  logic [SW-1:0]         ptr_slot,
   input  logic [2:0]            ptr_col,
   input  logic                  dat_wr,
   input  logic [4:0]            dat_in,
   input  logic [GW-1:0]         acq_group,
   input  logic                  hdr_valid,
   input  logic [27:0]           hdr_digit,
   input  logic [6:0]            hdr_err,
   output logic [SLOTS-1:0]      found_pulse,
   output logic [SLOTS-1:0]      capture_en,
   output logic [SLOTS-1:0]      page_found_n
);
   if (GROUPS < 1 || SLOTS < 1) begin : g_bad_size
      $error("pgm_page_matcher: GROUPS and SLOTS must be at least 1");
   end
   if (COLS * DIG_W != 28 || ENT_W != 5) begin : g_bad_fmt
      $error("pgm_page_matcher: entry format does not fit the port widths");
   end

   entry_t           req_w [TOTAL][COLS];
   logic [TOTAL-1:0] wr_hit_w;
   logic [TOTAL-1:0] rel_w;
   logic [TOTAL-1:0] match_w;
   logic [TOTAL-1:0] fp_all;
   logic [TOTAL-1:0] cap_all;
   logic [TOTAL-1:0] fn_all;
   logic             valid_q;
   logic [GW-1:0]    grp_q;

   pgm_req_store #(.GROUPS(GROUPS), .SLOTS(SLOTS)) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .ptr_load  (ptr_load),
      .ptr_group (ptr_group),
      .ptr_slot  (ptr_slot),
      .ptr_col   (ptr_col),
      .dat_wr    (dat_wr),
      .dat_in    (dat_in),
      .req_o     (req_w),
      .wr_hit_o  (wr_hit_w),
      .release_o (rel_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         grp_q   <= '0;
      end else begin
         valid_q <= hdr_valid;
         grp_q   <= acq_group;
      end
   end

   for (genvar s = 0; s < TOTAL; s++) begin : g_slot
      logic res_valid;
      assign res_valid = valid_q && (int'(grp_q) == s / SLOTS);

      pgm_slot_cmp i_cmp (
         .clk       (clk),
         .rst_n     (rst_n),
         .hdr_valid (hdr_valid && (int'(acq_group) == s / SLOTS)),
         .hdr_digit (hdr_digit),
         .hdr_err   (hdr_err),
         .req_i     (req_w[s]),
         .match_q   (match_w[s])
      );

      pgm_slot_ctl i_ctl (
         .clk          (clk),
         .rst_n        (rst_n),
         .res_valid    (res_valid),
         .hit          (match_w[s]),
         .hold_flag    (req_w[s][0][HOLD_BIT]),
         .wr_hit       (wr_hit_w[s]),
         .hold_release (rel_w[s]),
         .found_pulse  (fp_all[s]),
         .capture_en   (cap_all[s]),
         .found_n      (fn_all[s])
      );
   end

   always_comb begin
      for (int i = 0; i < SLOTS; i++) begin
         found_pulse[i]  = fp_all[int'(acq_group) * SLOTS + i];
         capture_en[i]   = cap_all[int'(acq_group) * SLOTS + i];
         page_found_n[i] = fn_all[int'(acq_group) * SLOTS + i];
      end
   end

   // R7
   found_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|fp_all) |-> $past(hdr_valid, 2));

   // R7
   found_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|fp_all) && !$past(hdr_valid) |=> (fp_all == '0));
endmodule

// File: tb/test_pgm_page_matcher.sv
module test_pgm_page_matcher;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ptr_load = 1'b0;
   logic [0:0]  ptr_group = '0;
   logic [1:0]  ptr_slot = '0;
   logic [2:0]  ptr_col = '0;
   logic        dat_wr = 1'b0;
   logic [4:0]  dat_in = '0;
   logic [0:0]  acq_group = '0;
   logic        hdr_valid = 1'b0;
   logic [27:0] hdr_digit = '0;
   logic [6:0]  hdr_err = '0;
   logic [3:0]  found_pulse, capture_en, page_found_n;
   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   pgm_page_matcher i_pgm_page_matcher (
      .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_group(ptr_group),
      .ptr_slot(ptr_slot), .ptr_col(ptr_col), .dat_wr(dat_wr), .dat_in(dat_in),
      .acq_group(acq_group), .hdr_valid(hdr_valid), .hdr_digit(hdr_digit),
      .hdr_err(hdr_err), .found_pulse(found_pulse), .capture_en(capture_en),
      .page_found_n(page_found_n)
   );

   function automatic logic [27:0] dg(int m, int pt, int pu, int ht, int hu, int mt, int mu);
      return {4'(mu), 4'(mt), 4'(hu), 4'(ht), 4'(pu), 4'(pt), 4'(m)};
   endfunction

   typedef struct packed {
      logic [27:0] dig;
      logic [6:0]  err;
      logic [3:0]  exp_found;
      logic [3:0]  exp_cap;
   } vec_t;

   // slot0: mag1 p23 normal, slot1: mag1 p23 at 12:34, slot2: any page of mag4 with hold low, slot3 empty
   localparam vec_t VEC [9] = '{
      '{dg(1,2,3,1,2,3,4), 7'h00, 4'b0011, 4'b0011},   // timed and normal both match
      '{dg(1,2,3,0,0,0,0), 7'h00, 4'b0001, 4'b0001},   // subcode ignored by slot0
      '{dg(4,0,0,0,0,0,0), 7'h00, 4'b0100, 4'b0100},   // first capture freezes slot2
      '{dg(1,2,4,1,2,3,4), 7'h00, 4'b0000, 4'b0000},   // wrong units, capture drops
      '{dg(1,2,3,1,2,3,4), 7'h40, 4'b0001, 4'b0001},   // error on cared minutes units
      '{dg(1,2,3,1,2,3,4), 7'h08, 4'b0001, 4'b0001},   // error on hours tens, slot0 does not care
      '{dg(9,2,3,0,0,0,0), 7'h00, 4'b0001, 4'b0001},   // magazine bit 3 not compared
      '{dg(1,2,3,13,2,11,4), 7'h00, 4'b0011, 4'b0011}, // upper bits of tens ignored
      '{dg(4,5,6,0,0,0,0), 7'h00, 4'b0100, 4'b0000}    // frozen slot found but not re-armed
   };

   task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic load_ptr(input int g, input int s, input int c);
      @(negedge clk);
      ptr_load = 1'b1; ptr_group = 1'(g); ptr_slot = 2'(s); ptr_col = 3'(c);
      @(posedge clk); #1;
      ptr_load = 1'b0;
   endtask

   task automatic wr(input logic [4:0] d);
      @(negedge clk);
      dat_wr = 1'b1; dat_in = d;
      @(posedge clk); #1;
      dat_wr = 1'b0;
   endtask

   // returns one cycle after the result registers update
   task automatic send_hdr(input logic [27:0] d, input logic [6:0] e);
      @(negedge clk);
      hdr_valid = 1'b1; hdr_digit = d; hdr_err = e;
      @(posedge clk); #1;
      hdr_valid = 1'b0;
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R12
      chk("R12 found_pulse", found_pulse, 4'b0000);
      chk("R12 capture_en", capture_en, 4'b0000);
      chk("R12 page_found_n", page_found_n, 4'b1111);
      @(negedge clk); rst_n = 1'b1;

      // R1 programming through the pointer, columns advance on each write
      load_ptr(0, 0, 0);
      wr(5'b11001); wr(5'b10010); wr(5'b10011);
      load_ptr(0, 1, 0);
      wr(5'b11001); wr(5'b10010); wr(5'b10011);
      wr(5'b10001); wr(5'b10010); wr(5'b10011); wr(5'b10100);
      load_ptr(0, 2, 0);
      wr(5'b10100);
      load_ptr(1, 0, 0);
      wr(5'b11001); wr(5'b10010); wr(5'b10011);
      chk("R12 no found after writes", page_found_n, 4'b1111);

      for (int v = 0; v < 9; v++) begin
         send_hdr(VEC[v].dig, VEC[v].err);
         // R2 R3 R4 R5 R7 R10
         chk($sformatf("R7 vector %0d found (R2 R3 R4 R5)", v), found_pulse, VEC[v].exp_found);
         // R9 R10
         chk($sformatf("R9 vector %0d capture (R10)", v), capture_en, VEC[v].exp_cap);
      end
      @(posedge clk); #1;
      chk("R7 pulse lasts one cycle", found_pulse, 4'b0000);
      chk("R8 found status after table", page_found_n, 4'b1000);

      // R11 release freeze by writing hold flag high
      load_ptr(0, 2, 0);
      wr(5'b11100);
      chk("R8 write restores status", page_found_n, 4'b1100);
      send_hdr(dg(4,1,1,0,0,0,0), 7'h00);
      chk("R11 found after release", found_pulse, 4'b0100);
      chk("R11 capture after release", capture_en, 4'b0100);
      send_hdr(dg(4,2,2,0,0,0,0), 7'h00);
      chk("R11 hold high keeps re-arming", capture_en, 4'b0100);

      // R8 rewrite of one entry from a mid column
      load_ptr(0, 0, 1);
      wr(5'b10010);
      chk("R8 rewrite sets status high", page_found_n, 4'b1001);

      // R1 overflow: eighth write must be dropped
      load_ptr(0, 3, 0);
      wr(5'b10101); wr(5'b10110); wr(5'b10111);
      wr(5'b00000); wr(5'b00000); wr(5'b00000); wr(5'b00000);
      wr(5'b10001);
      send_hdr(dg(5,6,7,0,0,0,0), 7'h00);
      chk("R1 write past last column ignored", found_pulse, 4'b1000);

      // R6 group selection
      @(negedge clk); acq_group = 1'b1;
      send_hdr(dg(1,2,3,1,2,3,4), 7'h00);
      chk("R6 second group compared", found_pulse, 4'b0001);
      @(negedge clk); acq_group = 1'b0;
      send_hdr(dg(1,2,3,1,2,3,4), 7'h00);
      chk("R6 first group compared", found_pulse, 4'b0011);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule